// File: doc/BRIEF.md
# Clocked Serial Receiver with Overrun Lock

This block receives 8-bit frames over a clocked serial link and hands each finished byte to a host through a small register window. A control register selects the clock source. In master mode the block generates the transfer clock itself, by dividing the system clock by a programmable even ratio. In slave mode it follows a clock applied from outside. Bits are taken on the rising edge of the transfer clock, least significant bit first. The slave clock and the serial data both pass through a synchronizer before an edge detector in the system clock domain.

A finished frame lands in a data register and raises a data-ready flag. A host read of the data register clears that flag. If the next frame completes while the earlier byte is still unread, the block keeps the old byte, discards the new one and sets a sticky overrun flag. While that flag is set, reception stops completely, and in master mode the transfer clock stops too. Reception resumes only when the host writes the flag back to zero. Two level interrupt outputs report data-ready and overrun, each gated by its own enable bit.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, every register reads as zero except the clock-divider register, which reads its reset value 1. Both interrupts, `sck_out` and `sck_oe` are low. The register addresses are: 0 control, 1 status, 2 receive data, 3 clock divider. The control bits are: bit0 receive enable, bit1 master mode, bit2 receive-interrupt enable, bit3 error-interrupt enable. The status bits are: bit0 data ready, bit1 overrun.
- R2: While receive enable is 0, clock edges capture nothing. The data-ready flag stays 0, and a later enabled frame is received intact.
- R3: In slave mode, 8 rising edges on `sck_in` shift `sdi` in, LSB first. The byte is then placed in the data register and data ready is set.
- R4: In master mode, `sck_oe` is 1 and `sck_out` has a period of 2*(divider+1) system clocks. The clock idles low and runs only while receive is enabled and no overrun is pending.
- R5: `irq_rx` is high exactly while data ready and the receive-interrupt enable are both 1.
- R6: A host read of address 2 returns the stored byte and clears data ready.
- R7: When a frame completes while data ready is 1, the overrun flag sets, data ready stays 1 and the data register keeps the older byte.
- R8: `irq_err` is high exactly while the overrun flag and the error-interrupt enable are both 1.
- R9: While the overrun flag is 1, no frame is captured. Writing status with bit1=1 leaves the flag set. Writing bit1=0 clears it and reception resumes.
- R10: Clearing receive enable in the middle of a frame discards the bits received so far. The next frame starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect on address 2) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from address |
| sck_in | input | 1 | Transfer clock input used in slave mode |
| sck_out | output | 1 | Generated transfer clock used in master mode |
| sck_oe | output | 1 | Drive enable for the transfer clock pin |
| sdi | input | 1 | Serial data input |
| irq_rx | output | 1 | Level interrupt: byte waiting |
| irq_err | output | 1 | Level interrupt: overrun pending |

## Verification
In slave mode, the data-ready and overrun flags change on the third system clock edge after `sck_in` rises: two synchronizer stages, then the capture edge. The bench therefore holds each clock level for four cycles and reads the flags only after the frame has settled. In master mode, a frame completes on the same system edge that raises `sck_out` for the eighth time. The bench updates `sdi` just after each such rise and checks two cycles later. Register reads take effect on the following edge and both interrupts follow the flags in the same cycle, so all host accesses and samples happen at the falling clock edge.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

   localparam int unsigned ADDR_W    = 2;
   localparam int unsigned CTRL_BITS = 4;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_DIV  = 2'd3
   } reg_sel_e;

   // bit0 enable, bit1 master, bit2 rx irq enable, bit3 error irq enable
   typedef struct packed {
      logic err_ie;
      logic rx_ie;
      logic master;
      logic rx_en;
   } ctrl_t;

endpackage

// File: rtl/ssrx_clk_src.sv
module ssrx_clk_src #(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MASTER_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master_sel,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   input  logic             sck_in,
   input  logic             sdi,
   output logic             rise,
   output logic             bit_val,
   output logic             sclk
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sck_pipe;
   logic [SYNC_STAGES-1:0] sdi_pipe;
   logic                   sck_prev;
   logic                   s_rise;
   logic                   m_rise;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_pipe[0] <= 1'b0;
               sdi_pipe[0] <= 1'b0;
            end else begin
               sck_pipe[0] <= sck_in;
               sdi_pipe[0] <= sdi;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_pipe[i] <= 1'b0;
               sdi_pipe[i] <= 1'b0;
            end else begin
               sck_pipe[i] <= sck_pipe[i-1];
               sdi_pipe[i] <= sdi_pipe[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_pipe[SYNC_STAGES-1];
   end

   assign s_rise = sck_pipe[SYNC_STAGES-1] & ~sck_prev;

   if (MASTER_EN) begin : g_master
      logic [DIV_W-1:0] hcnt;
      logic             sclk_q;
      logic             active;

      assign active = master_sel & run;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hcnt   <= '0;
            sclk_q <= 1'b0;
         end else if (!active) begin
            hcnt   <= '0;
            sclk_q <= 1'b0;
         end else if (hcnt == div) begin
            hcnt   <= '0;
            sclk_q <= ~sclk_q;
         end else begin
            hcnt   <= hcnt + 1'b1;
         end
      end

      assign m_rise = active && (hcnt == div) && !sclk_q;
      assign sclk   = sclk_q;

      // R4: generated clock parks low whenever reception may not run
      a_r4_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
         !active |=> !sclk_q);
   end else begin : g_slave_only
      logic unused_master_in;
      assign unused_master_in = ^{div, run};
      assign m_rise = 1'b0;
      assign sclk   = 1'b0;
   end

   assign rise    = (MASTER_EN && master_sel) ? m_rise : s_rise;
   assign bit_val = (MASTER_EN && master_sel) ? sdi : sdi_pipe[SYNC_STAGES-1];

endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
   parameter int unsigned FRAME_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  rise,
   input  logic                  bit_val,
   output logic                  done,
   output logic [FRAME_BITS-1:0] frame
);

   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("FRAME_BITS must be at least 2");
   end

   localparam int unsigned          CNT_W = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0]     LAST  = CNT_W'(FRAME_BITS - 1);

   logic [CNT_W-1:0]      cnt;
   logic [FRAME_BITS-1:0] shreg;
   logic                  step;

   assign step  = run & rise;
   assign frame = {bit_val, shreg[FRAME_BITS-1:1]};
   assign done  = step && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (!run) begin
         cnt   <= '0;
      end else if (rise) begin
         shreg <= frame;
         cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   // R10/R2: a stopped receiver always restarts a frame from bit 0
   a_r10_counter_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/ssrx_regs.sv
module ssrx_regs
   import ssrx_pkg::*;
#(
   parameter int unsigned BUS_W      = 8,
   parameter int unsigned FRAME_BITS = 8,
   parameter int unsigned DIV_W      = 8,
   parameter int unsigned DIV_RST    = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic                  rd,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [BUS_W-1:0]      wdata,
   output logic [BUS_W-1:0]      rdata,
   input  logic                  done,
   input  logic [FRAME_BITS-1:0] frame,
   output ctrl_t                 ctrl,
   output logic [DIV_W-1:0]      div,
   output logic                  full,
   output logic                  ovr
);

   if (BUS_W < CTRL_BITS || BUS_W < FRAME_BITS || BUS_W < DIV_W) begin : g_bad_bus
      $error("BUS_W too narrow for register contents");
   end
   if (DIV_RST >= (1 << DIV_W)) begin : g_bad_div
      $error("DIV_RST does not fit DIV_W");
   end

   logic [FRAME_BITS-1:0] data_q;
   logic                  rd_data;
   logic                  ovr_clr;
   logic                  busy;
   logic                  unused_wbits;

   assign unused_wbits = ^wdata;
   assign rd_data = rd && (reg_sel_e'(addr) == REG_DATA);
   assign ovr_clr = wr && (reg_sel_e'(addr) == REG_STAT) && !wdata[1];
   assign busy    = full && !rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         div  <= DIV_W'(DIV_RST);
      end else if (wr) begin
         if (reg_sel_e'(addr) == REG_CTRL) ctrl <= ctrl_t'(wdata[CTRL_BITS-1:0]);
         if (reg_sel_e'(addr) == REG_DIV)  div  <= wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full   <= 1'b0;
         ovr    <= 1'b0;
      end else begin
         if (done) begin
            if (busy) begin
               ovr    <= 1'b1;
            end else begin
               data_q <= frame;
               full   <= 1'b1;
            end
         end else begin
            if (rd_data) full <= 1'b0;
            if (ovr_clr) ovr  <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (reg_sel_e'(addr))
         REG_CTRL: rdata[CTRL_BITS-1:0]  = ctrl;
         REG_STAT: rdata[1:0]            = {ovr, full};
         REG_DATA: rdata[FRAME_BITS-1:0] = data_q;
         REG_DIV:  rdata[DIV_W-1:0]      = div;
         default:  rdata                 = '0;
      endcase
   end

   a_r3_frame_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !busy) |=> (full && data_q == $past(frame)));

   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !done) |=> !full);

   a_r7_old_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && busy) |=> (ovr && full && data_q == $past(data_q)));

   a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr);

   a_r9_no_capture_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> $stable(data_q));

endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
   import ssrx_pkg::*;
#(
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned FRAME_BITS  = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned DIV_RST     = 1,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MASTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [BUS_W-1:0]  host_wdata,
   output logic [BUS_W-1:0]  host_rdata,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              sdi,
   output logic              irq_rx,
   output logic              irq_err
);

   ctrl_t                 ctrl;
   logic [DIV_W-1:0]      div;
   logic                  full;
   logic                  ovr;
   logic                  run;
   logic                  rise;
   logic                  bit_val;
   logic                  done;
   logic [FRAME_BITS-1:0] frame;

   assign run = ctrl.rx_en & ~ovr;

   ssrx_regs #(
      .BUS_W      (BUS_W),
      .FRAME_BITS (FRAME_BITS),
      .DIV_W      (DIV_W),
      .DIV_RST    (DIV_RST)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (host_wr),
      .rd    (host_rd),
      .addr  (host_addr),
      .wdata (host_wdata),
      .rdata (host_rdata),
      .done  (done),
      .frame (frame),
      .ctrl  (ctrl),
      .div   (div),
      .full  (full),
      .ovr   (ovr)
   );

   ssrx_clk_src #(
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC_STAGES),
      .MASTER_EN   (MASTER_EN)
   ) u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_sel (ctrl.master),
      .run        (run),
      .div        (div),
      .sck_in     (sck_in),
      .sdi        (sdi),
      .rise       (rise),
      .bit_val    (bit_val),
      .sclk       (sck_out)
   );

   ssrx_shifter #(
      .FRAME_BITS (FRAME_BITS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .rise    (rise),
      .bit_val (bit_val),
      .done    (done),
      .frame   (frame)
   );

   assign sck_oe  = MASTER_EN && ctrl.master;
   assign irq_rx  = full & ctrl.rx_ie;
   assign irq_err = ovr & ctrl.err_ie;

   // R9: a locked receiver completes no frame
   a_r9_locked_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && $past(ovr)) |-> !done);

   // R5: the byte-waiting interrupt rises only together with or after a stored byte
   a_r5_irq_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_rx) |-> (full && ctrl.rx_ie));

endmodule

// File: tb/sync_serial_rx_tb.sv
module sync_serial_rx_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       sck_in = 1'b0;
   logic       sck_out;
   logic       sck_oe;
   logic       sdi = 1'b0;
   logic       irq_rx;
   logic       irq_err;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sync_serial_rx u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .sck_in     (sck_in),
      .sck_out    (sck_out),
      .sck_oe     (sck_oe),
      .sdi        (sdi),
      .irq_rx     (irq_rx),
      .irq_err    (irq_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] a, input logic [7:0] v);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   // slave clock: each level held 4 system cycles, data settled 3 cycles ahead
   task automatic slave_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sdi = b[i];
         repeat (3) @(negedge clk);
         sck_in = 1'b1;
         repeat (4) @(negedge clk);
         sck_in = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   // master clock: present each bit before the next rise of sck_out
   task automatic master_bits(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         sdi = b[i];
         @(posedge sck_out);
         #1;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      host_read(2'd0, v); check("R1 ctrl reset", v, 8'h00);
      host_read(2'd1, v); check("R1 status reset", v, 8'h00);
      host_read(2'd3, v); check("R1 divider reset", v, 8'h01);
      check("R1 irq_rx reset", irq_rx, 1'b0);
      check("R1 irq_err reset", irq_err, 1'b0);
      check("R1 sck_out reset", sck_out, 1'b0);
      check("R1 sck_oe reset", sck_oe, 1'b0);
   endtask

   task automatic t_disabled;
      logic [7:0] v;
      slave_bits(8'hFF, 8);
      slave_bits(8'hFF, 3);
      host_read(2'd1, v); check("R2 nothing captured while disabled", v, 8'h00);
      host_write(2'd0, 8'h01);
      slave_bits(8'hA5, 8);
      host_read(2'd1, v); check("R3 data ready after 8 slave edges", v, 8'h01);
      check("R5 irq_rx low with enable clear", irq_rx, 1'b0);
      host_write(2'd0, 8'h05);
      #1 check("R5 irq_rx high with byte and enable", irq_rx, 1'b1);
      host_read(2'd2, v); check("R3 R2 byte received LSB first", v, 8'hA5);
      host_read(2'd1, v); check("R6 read clears data ready", v, 8'h00);
      check("R5 irq_rx low after read", irq_rx, 1'b0);
   endtask

   task automatic t_overrun;
      logic [7:0] v;
      host_write(2'd0, 8'h01);
      slave_bits(8'h11, 8);
      slave_bits(8'h22, 8);
      host_read(2'd1, v); check("R7 overrun and ready set", v, 8'h03);
      check("R8 irq_err low with enable clear", irq_err, 1'b0);
      host_write(2'd0, 8'h09);
      #1 check("R8 irq_err high with enable", irq_err, 1'b1);
      host_read(2'd2, v); check("R7 older byte kept", v, 8'h11);
      slave_bits(8'h33, 8);
      host_read(2'd1, v); check("R9 no capture while locked", v, 8'h02);
      host_write(2'd1, 8'h02);
      host_read(2'd1, v); check("R9 writing one keeps overrun", v, 8'h02);
      host_write(2'd1, 8'h00);
      host_read(2'd1, v); check("R9 writing zero clears overrun", v, 8'h00);
      check("R8 irq_err low after clear", irq_err, 1'b0);
      slave_bits(8'h44, 8);
      host_read(2'd2, v); check("R9 reception resumes", v, 8'h44);
   endtask

   task automatic t_abort;
      logic [7:0] v;
      host_write(2'd0, 8'h01);
      slave_bits(8'hFF, 5);
      host_read(2'd1, v); check("R10 partial frame not stored", v, 8'h00);
      host_write(2'd0, 8'h00);
      host_write(2'd0, 8'h01);
      slave_bits(8'h5A, 8);
      host_read(2'd2, v); check("R10 frame after abort aligned", v, 8'h5A);
      host_write(2'd0, 8'h00);
   endtask

   task automatic t_master;
      logic [7:0] v;
      time t0;
      time t1;
      int highs;
      host_write(2'd3, 8'h02);
      sdi = 1'b0;
      host_write(2'd0, 8'h03);
      check("R4 sck_oe in master mode", sck_oe, 1'b1);
      @(posedge sck_out); t0 = $time;
      @(posedge sck_out); t1 = $time;
      check("R4 master period in cycles", 32'((t1 - t0) / 10), 32'd6);
      host_write(2'd0, 8'h02);
      highs = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (sck_out) highs++;
      end
      check("R4 clock idle when disabled", highs, 0);
      sdi = 1'b1;
      host_write(2'd0, 8'h03);
      master_bits(8'hC3);
      host_read(2'd1, v); check("R4 master frame ready", v, 8'h01);
      master_bits(8'h96);
      host_read(2'd1, v); check("R7 master overrun", v, 8'h03);
      highs = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (sck_out) highs++;
      end
      check("R9 R4 clock halted during overrun", highs, 0);
      host_read(2'd2, v); check("R7 master older byte kept", v, 8'hC3);
      host_write(2'd0, 8'h00);
      host_write(2'd1, 8'h00);
      host_read(2'd1, v); check("R9 master overrun cleared", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_overrun();
      t_abort();
      t_master();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule